// File: doc/BRIEF.md
# Operand Forwarding Unit

This block selects where each of the two ALU operands in the execute stage of a five-stage pipeline comes from. For each execute-stage source index, it compares the index against the destination and write enable of the two younger pipeline registers. It then steers the operand from one of three sources: the register value latched when the instruction left decode, the ALU result waiting at the output of execute, or the final value being written back. When both younger stages target the same register, the more recent producer, which is the one nearer to execute, wins. Register zero is never forwarded.

The block also holds the register file that the decode stage reads. That file is write-first: an index written back in a cycle reads as the new value in that same cycle. This removes the need for a third forwarding path from write-back to decode. A load sitting at the output of execute cannot supply its data yet. When a load is matched there, the block raises a hazard flag and keeps the operand on the latched register value, so that the stall logic around the block can act.

Top module: `operand_fwd_unit`

## Requirements
- R1: When exMemWe is 1, exMemLoad is 0, exMemDst is nonzero and exMemDst equals an operand's source index, that operand's select is 2'b01 and the operand equals exMemAlu.
- R2: When memWbWe is 1, memWbDst is nonzero and memWbDst equals an operand's source index, and the EX/MEM comparison of R1/R9 does not match, the select is 2'b10 and the operand equals the write-back value.
- R3: When both stages match the same source index, the EX/MEM stage takes priority. This applies both to forwarding (select 2'b01) and to the load case of R9.
- R4: A source index of 0 always gives select 2'b00, and the operand equals the latched register value, even when a younger stage writes register 0.
- R5: The write-back value is memWbMemData when memWbLoad is 1, and memWbAlu otherwise. This value is used both for forwarding and for the register-file write.
- R6: Operand A and operand B are selected independently of each other.
- R7: When the write-back stage writes a nonzero index in a cycle, a decode read of that index in the same cycle returns the write-back value.
- R8: A write-back to a nonzero index is stored at the clock edge and read back in later cycles. Writes to index 0 are dropped, and index 0 always reads 0.
- R9: When exMemWe and exMemLoad are 1 and exMemDst is nonzero and matches a source index, the select is 2'b00, the operand is the latched register value, and loadUseHaz is 1. Without such a match, loadUseHaz is 0.
- R10: After reset, every register reads 0.
- R11: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| idSrcA | input | IDX_W | Decode read index, port A |
| idSrcB | input | IDX_W | Decode read index, port B |
| idRdA | output | DATA_W | Decode read data, port A |
| idRdB | output | DATA_W | Decode read data, port B |
| exSrcA | input | IDX_W | Execute-stage source index, operand A |
| exSrcB | input | IDX_W | Execute-stage source index, operand B |
| exRegA | input | DATA_W | Latched register value, operand A |
| exRegB | input | DATA_W | Latched register value, operand B |
| exMemWe | input | 1 | EX/MEM register write enable |
| exMemLoad | input | 1 | EX/MEM instruction is a load |
| exMemDst | input | IDX_W | EX/MEM destination index |
| exMemAlu | input | DATA_W | EX/MEM ALU result |
| memWbWe | input | 1 | MEM/WB register write enable |
| memWbLoad | input | 1 | MEM/WB instruction is a load |
| memWbDst | input | IDX_W | MEM/WB destination index |
| memWbAlu | input | DATA_W | MEM/WB ALU result |
| memWbMemData | input | DATA_W | MEM/WB loaded data |
| fwdSelA | output | 2 | Operand A select (00 reg, 01 EX/MEM, 10 MEM/WB) |
| fwdSelB | output | 2 | Operand B select (same encoding) |
| opA | output | DATA_W | Forwarded operand A |
| opB | output | DATA_W | Forwarded operand B |
| loadUseHaz | output | 1 | A load in EX/MEM feeds an execute operand |

## Verification
Two functions can fall in the same cycle.

The first pair is the two forwarding paths: they compete when both younger stages target the same register. Directed cycles give both stages the same destination, once with an ALU result and once with a load at EX/MEM. The result is judged by the select, by the operand value and by the hazard flag.

The second pair is the register-file write and the bypassed decode read, which coincide when write-back and decode share an index. Here the read is compared against the write-back value in that cycle and against a shadow copy in later cycles. Random cycles with indices biased toward a few registers create both kinds of collision often, on both operands at once.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_REG   = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    fwd_sel_e   selA;
    fwd_sel_e   selB;
    logic       wrEn;
    logic       wbFromMem;
    logic [1:0] byp;
  } fwd_strobe_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] exSrcA,
  input  logic [IDX_W-1:0] exSrcB,
  input  logic [IDX_W-1:0] idSrcA,
  input  logic [IDX_W-1:0] idSrcB,
  input  logic             exMemWe,
  input  logic             exMemLoad,
  input  logic [IDX_W-1:0] exMemDst,
  input  logic             memWbWe,
  input  logic             memWbLoad,
  input  logic [IDX_W-1:0] memWbDst,
  output fwd_strobe_t      strobe,
  output logic             loadUseHaz
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic exLive, wbLive;
  logic [1:0] exHit, wbHit, ldHit;
  logic [1:0][IDX_W-1:0] exSrc, idSrc;
  fwd_sel_e sel [2];

  assign exLive = exMemWe && (exMemDst != ZERO_IDX);
  assign wbLive = memWbWe && (memWbDst != ZERO_IDX);
  assign exSrc  = {exSrcB, exSrcA};
  assign idSrc  = {idSrcB, idSrcA};

  for (genvar p = 0; p < 2; p++) begin : g_opnd
    assign exHit[p] = exLive && (exSrc[p] == exMemDst);
    assign wbHit[p] = wbLive && (exSrc[p] == memWbDst);
    assign ldHit[p] = exHit[p] && exMemLoad;
    always_comb begin
      if (exHit[p])      sel[p] = exMemLoad ? SEL_REG : SEL_EXMEM;
      else if (wbHit[p]) sel[p] = SEL_MEMWB;
      else               sel[p] = SEL_REG;
    end
    assign strobe.byp[p] = wbLive && (idSrc[p] == memWbDst);
  end

  assign strobe.selA      = sel[0];
  assign strobe.selB      = sel[1];
  assign strobe.wrEn      = wbLive;
  assign strobe.wbFromMem = memWbLoad;
  assign loadUseHaz       = |ldHit;
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwd_strobe_t       strobe,
  input  logic [IDX_W-1:0]  idSrcA,
  input  logic [IDX_W-1:0]  idSrcB,
  output logic [DATA_W-1:0] idRdA,
  output logic [DATA_W-1:0] idRdB,
  input  logic [DATA_W-1:0] exRegA,
  input  logic [DATA_W-1:0] exRegB,
  input  logic [DATA_W-1:0] exMemAlu,
  input  logic [IDX_W-1:0]  memWbDst,
  input  logic [DATA_W-1:0] memWbAlu,
  input  logic [DATA_W-1:0] memWbMemData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic [DATA_W-1:0] regs [REG_N];
  logic [DATA_W-1:0] wbValue;
  logic [1:0][IDX_W-1:0]  rdIdx;
  logic [1:0][DATA_W-1:0] rdData, latched, opnd;
  fwd_sel_e sel [2];

  assign wbValue = strobe.wbFromMem ? memWbMemData : memWbAlu;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
    end else if (strobe.wrEn) begin
      regs[memWbDst] <= wbValue;
    end
  end

  assign rdIdx   = {idSrcB, idSrcA};
  assign latched = {exRegB, exRegA};
  assign sel[0]  = strobe.selA;
  assign sel[1]  = strobe.selB;

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      if (rdIdx[p] == ZERO_IDX) rdData[p] = '0;
      else if (strobe.byp[p])   rdData[p] = wbValue;
      else                      rdData[p] = regs[rdIdx[p]];
    end
    always_comb begin
      unique case (sel[p])
        SEL_EXMEM: opnd[p] = exMemAlu;
        SEL_MEMWB: opnd[p] = wbValue;
        default:   opnd[p] = latched[p];
      endcase
    end
  end

  assign idRdA = rdData[0];
  assign idRdB = rdData[1];
  assign opA   = opnd[0];
  assign opB   = opnd[1];
endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  idSrcA,
  input  logic [IDX_W-1:0]  idSrcB,
  output logic [DATA_W-1:0] idRdA,
  output logic [DATA_W-1:0] idRdB,
  input  logic [IDX_W-1:0]  exSrcA,
  input  logic [IDX_W-1:0]  exSrcB,
  input  logic [DATA_W-1:0] exRegA,
  input  logic [DATA_W-1:0] exRegB,
  input  logic              exMemWe,
  input  logic              exMemLoad,
  input  logic [IDX_W-1:0]  exMemDst,
  input  logic [DATA_W-1:0] exMemAlu,
  input  logic              memWbWe,
  input  logic              memWbLoad,
  input  logic [IDX_W-1:0]  memWbDst,
  input  logic [DATA_W-1:0] memWbAlu,
  input  logic [DATA_W-1:0] memWbMemData,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic              loadUseHaz
);
  fwd_strobe_t strobe;

  fwd_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .exSrcA(exSrcA), .exSrcB(exSrcB), .idSrcA(idSrcA), .idSrcB(idSrcB),
    .exMemWe(exMemWe), .exMemLoad(exMemLoad), .exMemDst(exMemDst),
    .memWbWe(memWbWe), .memWbLoad(memWbLoad), .memWbDst(memWbDst),
    .strobe(strobe), .loadUseHaz(loadUseHaz)
  );

  fwd_datapath #(.DATA_W(DATA_W), .REG_N(REG_N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .idSrcA(idSrcA), .idSrcB(idSrcB), .idRdA(idRdA), .idRdB(idRdB),
    .exRegA(exRegA), .exRegB(exRegB), .exMemAlu(exMemAlu),
    .memWbDst(memWbDst), .memWbAlu(memWbAlu), .memWbMemData(memWbMemData),
    .opA(opA), .opB(opB)
  );

  assign fwdSelA = strobe.selA;
  assign fwdSelB = strobe.selB;
endmodule

// File: rtl/operand_fwd_unit_chk.sv
module operand_fwd_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [IDX_W-1:0]  idSrcA,
  input logic [DATA_W-1:0] idRdA,
  input logic [IDX_W-1:0]  exSrcA,
  input logic [IDX_W-1:0]  exSrcB,
  input logic [DATA_W-1:0] exRegA,
  input logic              exMemWe,
  input logic              exMemLoad,
  input logic [IDX_W-1:0]  exMemDst,
  input logic [DATA_W-1:0] exMemAlu,
  input logic              memWbWe,
  input logic              memWbLoad,
  input logic [IDX_W-1:0]  memWbDst,
  input logic [DATA_W-1:0] memWbAlu,
  input logic [DATA_W-1:0] memWbMemData,
  input logic [1:0]        fwdSelA,
  input logic [1:0]        fwdSelB,
  input logic [DATA_W-1:0] opA,
  input logic              loadUseHaz
);
  logic [DATA_W-1:0] wbSeen;
  logic exMatchA, wbMatchA;
  assign wbSeen   = memWbLoad ? memWbMemData : memWbAlu;
  assign exMatchA = exMemWe && exMemDst != '0 && exMemDst == exSrcA;
  assign wbMatchA = memWbWe && memWbDst != '0 && memWbDst == exSrcA;

  assert_exmem_fwd_R1: assert property (@(posedge clk) disable iff (!rstN)
    (exMatchA && !exMemLoad) |-> (fwdSelA == 2'b01 && opA == exMemAlu));
  assert_memwb_fwd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wbMatchA && !exMatchA) |-> (fwdSelA == 2'b10 && opA == wbSeen));
  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    (exSrcA == '0) |-> (fwdSelA == 2'b00 && opA == exRegA));
  assert_load_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (exMatchA && exMemLoad) |-> (loadUseHaz && fwdSelA == 2'b00));
  assert_wr_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memWbWe && memWbDst != '0 && memWbDst == idSrcA) |-> (idRdA == wbSeen));
  assert_zero_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (idSrcA == '0) |-> (idRdA == '0));
  assert_sel_legal_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelA != 2'b11 && fwdSelB != 2'b11));
  assert_hold_reg_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!exMatchA && !wbMatchA) |-> (fwdSelA == 2'b00 && opA == exRegA));
endmodule

bind operand_fwd_unit operand_fwd_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .idSrcA(idSrcA), .idRdA(idRdA),
  .exSrcA(exSrcA), .exSrcB(exSrcB), .exRegA(exRegA),
  .exMemWe(exMemWe), .exMemLoad(exMemLoad), .exMemDst(exMemDst), .exMemAlu(exMemAlu),
  .memWbWe(memWbWe), .memWbLoad(memWbLoad), .memWbDst(memWbDst),
  .memWbAlu(memWbAlu), .memWbMemData(memWbMemData),
  .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .opA(opA), .loadUseHaz(loadUseHaz)
);

// File: tb/operand_fwd_unit_bench.sv
`timescale 1ns/1ps
module operand_fwd_unit_bench;
  localparam int DW = 32;
  localparam int RN = 8;
  localparam int IW = $clog2(RN);

  logic clk = 1'b0, rstN = 1'b0;
  logic [IW-1:0] idSrcA, idSrcB, exSrcA, exSrcB, exMemDst, memWbDst;
  logic [DW-1:0] idRdA, idRdB, exRegA, exRegB, exMemAlu, memWbAlu, memWbMemData, opA, opB;
  logic exMemWe, exMemLoad, memWbWe, memWbLoad, loadUseHaz;
  logic [1:0] fwdSelA, fwdSelB;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [DW-1:0] shadow [RN];

  always #10 clk = ~clk;

  operand_fwd_unit #(.DATA_W(DW), .REG_N(RN)) u_operand_fwd_unit (
    .clk(clk), .rstN(rstN), .idSrcA(idSrcA), .idSrcB(idSrcB), .idRdA(idRdA), .idRdB(idRdB),
    .exSrcA(exSrcA), .exSrcB(exSrcB), .exRegA(exRegA), .exRegB(exRegB),
    .exMemWe(exMemWe), .exMemLoad(exMemLoad), .exMemDst(exMemDst), .exMemAlu(exMemAlu),
    .memWbWe(memWbWe), .memWbLoad(memWbLoad), .memWbDst(memWbDst), .memWbAlu(memWbAlu),
    .memWbMemData(memWbMemData), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .opA(opA), .opB(opB), .loadUseHaz(loadUseHaz)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wbVal();
    return memWbLoad ? memWbMemData : memWbAlu;
  endfunction

  function automatic logic [1:0] expSel(input logic [IW-1:0] src);
    if (exMemWe && exMemDst != 0 && exMemDst == src) return 2'b00 | {1'b0, !exMemLoad};
    if (memWbWe && memWbDst != 0 && memWbDst == src) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] expOp(input logic [1:0] s, input logic [DW-1:0] reg_v);
    return (s == 2'b01) ? exMemAlu : (s == 2'b10) ? wbVal() : reg_v;
  endfunction

  function automatic logic [DW-1:0] expRd(input logic [IW-1:0] idx);
    if (idx == 0) return '0;
    if (memWbWe && memWbDst == idx) return wbVal();
    return shadow[idx];
  endfunction

  function automatic logic expHaz();
    return exMemWe && exMemLoad && exMemDst != 0 && (exMemDst == exSrcA || exMemDst == exSrcB);
  endfunction

  task automatic checkAll(input string tag);
    logic [1:0] sa, sb;
    sa = expSel(exSrcA);
    sb = expSel(exSrcB);
    chk({tag, " selA R1 R2 R3 R4"}, DW'(fwdSelA), DW'(sa));
    chk({tag, " selB R6"}, DW'(fwdSelB), DW'(sb));
    chk({tag, " opA R5 R11"}, opA, expOp(sa, exRegA));
    chk({tag, " opB R6"}, opB, expOp(sb, exRegB));
    chk({tag, " haz R9"}, DW'(loadUseHaz), DW'(expHaz()));
    chk({tag, " rdA R7 R8"}, idRdA, expRd(idSrcA));
    chk({tag, " rdB R7 R8"}, idRdB, expRd(idSrcB));
  endtask

  task automatic idle();
    idSrcA = 0; idSrcB = 0; exSrcA = 0; exSrcB = 0; exRegA = 32'h11; exRegB = 32'h22;
    exMemWe = 0; exMemLoad = 0; exMemDst = 0; exMemAlu = 32'hE0;
    memWbWe = 0; memWbLoad = 0; memWbDst = 0; memWbAlu = 32'hA0; memWbMemData = 32'hD0;
  endtask

  always @(posedge clk)
    if (rstN && memWbWe && memWbDst != 0) shadow[memWbDst] = wbVal();

  function automatic logic [IW-1:0] rIdx();
    return ($urandom % 2) ? IW'($urandom % 4) : IW'($urandom % RN);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < RN; i++) shadow[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < RN; i++) begin
      idSrcA = IW'(i); #2;
      chk("reset read R10", idRdA, '0);
    end
    // add r3 then sub reading r3: EX/MEM path
    idle(); exSrcA = 3; exRegA = 32'h5; exMemWe = 1; exMemDst = 3; exMemAlu = 32'h33; #2;
    chk("back-to-back sel R1", DW'(fwdSelA), 32'h1);
    chk("back-to-back op R1", opA, 32'h33);
    checkAll("dir1");
    // distance two: MEM/WB path
    @(negedge clk); idle(); exSrcB = 3; exMemWe = 1; exMemDst = 5; memWbWe = 1; memWbDst = 3; memWbAlu = 32'h77; #2;
    chk("distance-2 sel R2", DW'(fwdSelB), 32'h2);
    chk("distance-2 op R2", opB, 32'h77);
    checkAll("dir2");
    // both stages match: nearer wins
    @(negedge clk); idle(); exSrcA = 4; exSrcB = 4; exMemWe = 1; exMemDst = 4; exMemAlu = 32'h44;
    memWbWe = 1; memWbDst = 4; memWbAlu = 32'h99; #2;
    chk("priority R3", DW'(fwdSelA), 32'h1);
    chk("priority op R3", opB, 32'h44);
    // index zero never forwarded
    @(negedge clk); idle(); exMemWe = 1; memWbWe = 1; #2;
    chk("r0 sel R4", DW'(fwdSelA), 32'h0);
    chk("r0 op R4", opA, 32'h11);
    // load at EX/MEM masks MEM/WB too
    @(negedge clk); idle(); exSrcA = 6; exMemWe = 1; exMemLoad = 1; exMemDst = 6;
    memWbWe = 1; memWbDst = 6; memWbAlu = 32'h66; #2;
    chk("load sel R9", DW'(fwdSelA), 32'h0);
    chk("load haz R9", DW'(loadUseHaz), 32'h1);
    chk("load op R9", opA, 32'h11);
    // load at MEM/WB supplies memory data, write-first read of the same index
    @(negedge clk); idle(); exSrcA = 2; idSrcB = 2; memWbWe = 1; memWbLoad = 1; memWbDst = 2;
    memWbAlu = 32'hBAD; memWbMemData = 32'hC0DE; #2;
    chk("wb load data R5", opA, 32'hC0DE);
    chk("write-first R7", idRdB, 32'hC0DE);
    @(negedge clk); idle(); idSrcA = 2; #2;
    chk("persist R8", idRdA, 32'hC0DE);
    // write to index zero dropped
    memWbWe = 1; memWbDst = 0; memWbAlu = 32'hFFFF; @(negedge clk); memWbWe = 0; idSrcA = 0; #2;
    chk("r0 write dropped R8", idRdA, '0);
    // random mix
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      idSrcA = rIdx(); idSrcB = rIdx(); exSrcA = rIdx(); exSrcB = rIdx();
      exRegA = $urandom; exRegB = $urandom; exMemAlu = $urandom; memWbAlu = $urandom; memWbMemData = $urandom;
      exMemWe = 1'($urandom); exMemLoad = (($urandom % 4) == 0); exMemDst = rIdx();
      memWbWe = 1'($urandom); memWbLoad = 1'($urandom); memWbDst = rIdx();
      #2;
      checkAll("rand");
    end
    @(negedge clk); idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule